// File: doc/BRIEF.md
# Maskable Interrupt Status Registers for a GPIB Interface

This block gathers event indications from the state machines of an instrument-bus (IEEE-488) interface. It keeps them in two sticky status registers, each with its own interrupt mask register, and drives a single interrupt line toward the host. Each event input is sampled on the rising clock edge. An event sets its status bit, and the bit stays set until the host reads that register. The read returns the value held before the clear. Some bits are set by a combination of handshake and addressing conditions. Others are set by any edge of a watched state signal, found by comparing the signal with a registered copy from the previous cycle.

The host reads a status register by pulsing its read strobe while it samples the register output. Mask registers are loaded from a shared write-data bus with one strobe per register. The interrupt line is the registered OR of every status bit ANDed with its mask bit. A configuration input can invert it so that it is active low.

Top module: `gpib_irq_status`

## Requirements
- R1: After a synchronous reset, both status registers and both masks read zero, and `irq_o` sits at its inactive level, which equals `irq_invert`.
- R2: A pulse on `ev_din` sets register 1 bit 0, and a pulse on `ev_cmd_out` sets register 2 bit 0. Both bits stay set after the pulse ends.
- R3: Register 1 bit 3 (END received) is set in a cycle where `lsn_act` and `acc_data` are both high and either `eoi_line` is high or `eos_hit` and `eos_rx_en` are both high. It is not set when `eos_hit` is high but `eos_rx_en` is low.
- R4: Register 1 bit 2 (error) is set by any of three conditions. The first is `talker_act` and `src_delay` high with both `hs_nrfd` and `hs_ndac` low. The second is `host_dout_wr` high while `src_idle` is high. The third is `src_delay` going low in a cycle where `src_idle` is high.
- R5: Register 1 bit 1 (data out) is set by `ev_dout_rdy`. It is cleared by `host_dout_wr` and by `talker_act` falling.
- R6: Register 2 bit 1 is set by any edge of `remote_st`, and bit 2 by any edge of `lockout_st`. A level held through reset sets neither bit.
- R7: Register 2 bit 3 is set by an edge on any bit of `addr_st`.
- R8: When `rd_stat1` or `rd_stat2` is high, that register's output shows its current value in that cycle and then clears. The other register is untouched.
- R9: If an event sets a bit in the same cycle that a read clears the register, the bit is set afterward.
- R10: `irq_o` updates one cycle after the status and mask registers. It equals the OR of (status AND mask) over both registers, XORed with `irq_invert`.
- R11: Status bits 4 and above always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_din | input | 1 | Listener accepted a data byte |
| ev_dout_rdy | input | 1 | Talker ready for the next output byte |
| ev_cmd_out | input | 1 | Controller ready for the next command byte |
| host_dout_wr | input | 1 | Host wrote the output data register |
| talker_act | input | 1 | Talker in its active state |
| src_delay | input | 1 | Source handshake in its delay state |
| src_idle | input | 1 | Source handshake idle |
| hs_nrfd | input | 1 | Not-ready-for-data line asserted |
| hs_ndac | input | 1 | Not-data-accepted line asserted |
| lsn_act | input | 1 | Listener in its active state |
| acc_data | input | 1 | Acceptor handshake in its accept state |
| eoi_line | input | 1 | End-or-identify line asserted |
| eos_hit | input | 1 | Received byte equals the end-of-string byte |
| eos_rx_en | input | 1 | End-of-string detection enabled |
| remote_st | input | 1 | Remote state |
| lockout_st | input | 1 | Local-lockout state |
| addr_st | input | 4 | Talker-addressed, listener-addressed, controller-in-charge, major/minor |
| rd_stat1 | input | 1 | Read strobe, status register 1 |
| rd_stat2 | input | 1 | Read strobe, status register 2 |
| mask1_wr | input | 1 | Load mask 1 from `mask_wdata` |
| mask2_wr | input | 1 | Load mask 2 from `mask_wdata` |
| mask_wdata | input | 8 | Mask write data |
| irq_invert | input | 1 | Make the interrupt active low |
| stat1_o | output | 8 | Status register 1 |
| stat2_o | output | 8 | Status register 2 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision of a set event with a clearing read in the same cycle. The bench reaches it by pulsing `ev_din` in the very cycle that `rd_stat1` is high, and by toggling `remote_st` during a read of register 2. The third error condition also takes care. It needs a cycle-to-cycle walk of the source handshake from delay to idle while no listener-free talker condition holds, so `hs_nrfd` is kept high and `talker_act` low during that step. A behavioural model, advanced on every clock, is compared against all three outputs each cycle.

// File: rtl/gpib_irq_pkg.sv
`timescale 1ns/1ps
package gpib_irq_pkg;
  localparam int N_EVT  = 4;
  localparam int ADDR_W = 4;
  localparam int B1_DIN  = 0;
  localparam int B1_DOUT = 1;
  localparam int B1_ERR  = 2;
  localparam int B1_END  = 3;
  localparam int B2_CMD  = 0;
  localparam int B2_REMC = 1;
  localparam int B2_LOKC = 2;
  localparam int B2_ADSC = 3;
endpackage

// File: rtl/gpib_irq_events.sv
`timescale 1ns/1ps
module gpib_irq_events
  import gpib_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_din_i,
  input  logic              ev_dout_i,
  input  logic              ev_cmd_i,
  input  logic              dout_wr_i,
  input  logic              talker_act_i,
  input  logic              src_delay_i,
  input  logic              src_idle_i,
  input  logic              nrfd_i,
  input  logic              ndac_i,
  input  logic              lsn_act_i,
  input  logic              acc_data_i,
  input  logic              eoi_i,
  input  logic              eos_hit_i,
  input  logic              eos_en_i,
  input  logic              remote_i,
  input  logic              lockout_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_EVT-1:0]  set1_o,
  output logic [N_EVT-1:0]  clr1_o,
  output logic [N_EVT-1:0]  set2_o
);
  // Previous-cycle copies; loaded with live values during reset so that
  // levels present at reset release are not seen as edges.
  logic              rem_q, lok_q, sdly_q, tact_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    rem_q  <= remote_i;
    lok_q  <= lockout_i;
    sdly_q <= src_delay_i;
    tact_q <= talker_act_i;
    addr_q <= addr_i;
  end

  logic err_nolsn, err_idlewr, err_drop, end_hit;

  always_comb begin
    err_nolsn  = talker_act_i & src_delay_i & ~nrfd_i & ~ndac_i;
    err_idlewr = dout_wr_i & src_idle_i;
    err_drop   = sdly_q & ~src_delay_i & src_idle_i;
    end_hit    = lsn_act_i & acc_data_i & (eoi_i | (eos_hit_i & eos_en_i));

    set1_o          = '0;
    set1_o[B1_DIN]  = ev_din_i;
    set1_o[B1_DOUT] = ev_dout_i;
    set1_o[B1_ERR]  = err_nolsn | err_idlewr | err_drop;
    set1_o[B1_END]  = end_hit;

    clr1_o          = '0;
    clr1_o[B1_DOUT] = dout_wr_i | (tact_q & ~talker_act_i);

    set2_o          = '0;
    set2_o[B2_CMD]  = ev_cmd_i;
    set2_o[B2_REMC] = remote_i ^ rem_q;
    set2_o[B2_LOKC] = lockout_i ^ lok_q;
    set2_o[B2_ADSC] = |(addr_i ^ addr_q);
  end

  // R6: an edge on the remote or lockout state raises its change request
  a_r6_remote_edge: assert property (@(posedge clk) disable iff (rst)
    (remote_i != $past(remote_i)) |-> set2_o[B2_REMC]);
  a_r6_lockout_edge: assert property (@(posedge clk) disable iff (rst)
    (lockout_i != $past(lockout_i)) |-> set2_o[B2_LOKC]);
  // R7: an edge on any address status bit raises the address change request
  a_r7_addr_edge: assert property (@(posedge clk) disable iff (rst)
    (addr_i != $past(addr_i)) |-> set2_o[B2_ADSC]);
endmodule

// File: rtl/gpib_irq_sticky.sv
`timescale 1ns/1ps
module gpib_irq_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         rd_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // Set has priority over both the read clear and the extra clear.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((rd_i ? '0 : q) & ~clr_i) | set_i;
  end

  assign q_o = q;

  // R9: a bit set in a cycle is held afterwards, even during a read
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));
  // R8: after a read only bits set in the read cycle remain
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> ((q & ~$past(set_i)) == '0));
endmodule

// File: rtl/gpib_irq_out.sv
`timescale 1ns/1ps
module gpib_irq_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat1_i,
  input  logic [W-1:0] stat2_i,
  input  logic [W-1:0] wdata_i,
  input  logic         m1_wr_i,
  input  logic         m2_wr_i,
  input  logic         inv_i,
  output logic         irq_o
);
  logic [W-1:0] mask1, mask2;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask1 <= '0;
      mask2 <= '0;
    end else begin
      if (m1_wr_i) mask1 <= wdata_i;
      if (m2_wr_i) mask2 <= wdata_i;
    end
  end

  logic pending;
  assign pending = (|(stat1_i & mask1)) | (|(stat2_i & mask2));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= inv_i;
    else     irq_q <= pending ^ inv_i;
  end

  assign irq_o = irq_q;

  // R10: with both status registers clear the line sits at its idle level
  a_r10_idle_level: assert property (@(posedge clk) disable iff (rst)
    ((stat1_i == '0) && (stat2_i == '0)) |=> (irq_o == $past(inv_i)));
  // R10: with every mask clear no status bit can raise the line
  a_r10_masked: assert property (@(posedge clk) disable iff (rst)
    ((mask1 == '0) && (mask2 == '0)) |=> (irq_o == $past(inv_i)));
endmodule

// File: rtl/gpib_irq_status.sv
`timescale 1ns/1ps
module gpib_irq_status
  import gpib_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_din,
  input  logic              ev_dout_rdy,
  input  logic              ev_cmd_out,
  input  logic              host_dout_wr,
  input  logic              talker_act,
  input  logic              src_delay,
  input  logic              src_idle,
  input  logic              hs_nrfd,
  input  logic              hs_ndac,
  input  logic              lsn_act,
  input  logic              acc_data,
  input  logic              eoi_line,
  input  logic              eos_hit,
  input  logic              eos_rx_en,
  input  logic              remote_st,
  input  logic              lockout_st,
  input  logic [ADDR_W-1:0] addr_st,
  input  logic              rd_stat1,
  input  logic              rd_stat2,
  input  logic              mask1_wr,
  input  logic              mask2_wr,
  input  logic [REG_W-1:0]  mask_wdata,
  input  logic              irq_invert,
  output logic [REG_W-1:0]  stat1_o,
  output logic [REG_W-1:0]  stat2_o,
  output logic              irq_o
);
  localparam int N_REG = 2;

  logic [N_EVT-1:0] set1_e, clr1_e, set2_e;

  gpib_irq_events u_events (
    .clk          (clk),
    .rst          (rst),
    .ev_din_i     (ev_din),
    .ev_dout_i    (ev_dout_rdy),
    .ev_cmd_i     (ev_cmd_out),
    .dout_wr_i    (host_dout_wr),
    .talker_act_i (talker_act),
    .src_delay_i  (src_delay),
    .src_idle_i   (src_idle),
    .nrfd_i       (hs_nrfd),
    .ndac_i       (hs_ndac),
    .lsn_act_i    (lsn_act),
    .acc_data_i   (acc_data),
    .eoi_i        (eoi_line),
    .eos_hit_i    (eos_hit),
    .eos_en_i     (eos_rx_en),
    .remote_i     (remote_st),
    .lockout_i    (lockout_st),
    .addr_i       (addr_st),
    .set1_o       (set1_e),
    .clr1_o       (clr1_e),
    .set2_o       (set2_e)
  );

  logic [N_REG-1:0][REG_W-1:0] set_v, clr_v, q_v;
  logic [N_REG-1:0]            rd_v;

  generate
    if (REG_W > N_EVT) begin : g_pad
      assign set_v[0] = {{(REG_W-N_EVT){1'b0}}, set1_e};
      assign clr_v[0] = {{(REG_W-N_EVT){1'b0}}, clr1_e};
      assign set_v[1] = {{(REG_W-N_EVT){1'b0}}, set2_e};
      assign clr_v[1] = '0;
    end else begin : g_exact
      assign set_v[0] = set1_e;
      assign clr_v[0] = clr1_e;
      assign set_v[1] = set2_e;
      assign clr_v[1] = '0;
    end
  endgenerate

  assign rd_v = {rd_stat2, rd_stat1};

  generate
    for (genvar g = 0; g < N_REG; g++) begin : g_reg
      gpib_irq_sticky #(.W(REG_W)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v[g]),
        .clr_i (clr_v[g]),
        .rd_i  (rd_v[g]),
        .q_o   (q_v[g])
      );
    end
  endgenerate

  assign stat1_o = q_v[0];
  assign stat2_o = q_v[1];

  gpib_irq_out #(.W(REG_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .stat1_i (q_v[0]),
    .stat2_i (q_v[1]),
    .wdata_i (mask_wdata),
    .m1_wr_i (mask1_wr),
    .m2_wr_i (mask2_wr),
    .inv_i   (irq_invert),
    .irq_o   (irq_o)
  );

  // R5: a host write with no concurrent ready event leaves data-out clear
  a_r5_write_clears_dout: assert property (@(posedge clk) disable iff (rst)
    (host_dout_wr && !ev_dout_rdy) |=> !stat1_o[B1_DOUT]);

  generate
    if (REG_W > N_EVT) begin : g_unused_chk
      // R11: positions without an event never read one
      a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (stat1_o[REG_W-1:N_EVT] == '0) && (stat2_o[REG_W-1:N_EVT] == '0));
    end
  endgenerate
endmodule

// File: tb/gpib_irq_status_bench.sv
`timescale 1ns/1ps
module gpib_irq_status_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic ev_din, ev_dout_rdy, ev_cmd_out, host_dout_wr;
  logic talker_act, src_delay, src_idle, hs_nrfd, hs_ndac;
  logic lsn_act, acc_data, eoi_line, eos_hit, eos_rx_en;
  logic remote_st, lockout_st;
  logic [3:0] addr_st;
  logic rd_stat1, rd_stat2, mask1_wr, mask2_wr, irq_invert;
  logic [7:0] mask_wdata;
  logic [7:0] stat1_o, stat2_o;
  logic irq_o;

  gpib_irq_status u_gpib_irq_status (
    .clk(clk), .rst(rst), .ev_din(ev_din), .ev_dout_rdy(ev_dout_rdy),
    .ev_cmd_out(ev_cmd_out), .host_dout_wr(host_dout_wr),
    .talker_act(talker_act), .src_delay(src_delay), .src_idle(src_idle),
    .hs_nrfd(hs_nrfd), .hs_ndac(hs_ndac), .lsn_act(lsn_act),
    .acc_data(acc_data), .eoi_line(eoi_line), .eos_hit(eos_hit),
    .eos_rx_en(eos_rx_en), .remote_st(remote_st), .lockout_st(lockout_st),
    .addr_st(addr_st), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
    .mask1_wr(mask1_wr), .mask2_wr(mask2_wr), .mask_wdata(mask_wdata),
    .irq_invert(irq_invert), .stat1_o(stat1_o), .stat2_o(stat2_o),
    .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // Behavioural reference, advanced on every clock edge
  logic [7:0] m_s1, m_s2, m_m1, m_m2, n1, n2;
  logic       m_irq;
  logic       p_rem, p_lok, p_sdly, p_tact;
  logic [3:0] p_addr;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_m1 <= 0; m_m2 <= 0; m_irq <= irq_invert;
    end else begin
      n1 = rd_stat1 ? 8'h00 : m_s1;
      if (host_dout_wr || (p_tact && !talker_act)) n1[1] = 1'b0;
      if (ev_din) n1[0] = 1'b1;
      if (ev_dout_rdy) n1[1] = 1'b1;
      if ((talker_act && src_delay && !hs_nrfd && !hs_ndac) ||
          (host_dout_wr && src_idle) || (p_sdly && !src_delay && src_idle))
        n1[2] = 1'b1;
      if (lsn_act && acc_data && (eoi_line || (eos_hit && eos_rx_en)))
        n1[3] = 1'b1;
      n2 = rd_stat2 ? 8'h00 : m_s2;
      if (ev_cmd_out) n2[0] = 1'b1;
      if (remote_st != p_rem) n2[1] = 1'b1;
      if (lockout_st != p_lok) n2[2] = 1'b1;
      if (addr_st != p_addr) n2[3] = 1'b1;
      m_irq <= (((m_s1 & m_m1) != 0) || ((m_s2 & m_m2) != 0)) ^ irq_invert;
      m_s1 <= n1;
      m_s2 <= n2;
      if (mask1_wr) m_m1 <= mask_wdata;
      if (mask2_wr) m_m2 <= mask_wdata;
    end
    p_rem <= remote_st; p_lok <= lockout_st; p_sdly <= src_delay;
    p_tact <= talker_act; p_addr <= addr_st;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    chk("R8 stat1 vs model", stat1_o, m_s1);
    chk("R8 stat2 vs model", stat2_o, m_s2);
    chk("R10 irq vs model", {7'd0, irq_o}, {7'd0, m_irq});
  endtask

  task automatic rd1();
    rd_stat1 = 1; tick(); rd_stat1 = 0;
  endtask

  task automatic rd2();
    rd_stat2 = 1; tick(); rd_stat2 = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1;
    {ev_din, ev_dout_rdy, ev_cmd_out, host_dout_wr} = '0;
    {talker_act, src_delay, src_idle, hs_nrfd, hs_ndac} = '0;
    {lsn_act, acc_data, eoi_line, eos_hit, eos_rx_en} = '0;
    remote_st = 1; lockout_st = 0; addr_st = 4'b0101;
    {rd_stat1, rd_stat2, mask1_wr, mask2_wr, irq_invert} = '0;
    mask_wdata = 0;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state, R6 no spurious change from levels held through reset
    chk("R1 stat1 after reset", stat1_o, 8'h00);
    chk("R6 stat2 after reset", stat2_o, 8'h00);
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);

    // R2 data-in sticky
    ev_din = 1; tick(); ev_din = 0;
    chk("R2 data-in set", stat1_o, 8'h01);
    tick();
    chk("R2 data-in sticky", stat1_o, 8'h01);
    rd_stat1 = 1;
    chk("R8 read returns value", stat1_o, 8'h01);
    tick(); rd_stat1 = 0;
    chk("R8 read clears", stat1_o, 8'h00);

    // R3 END: EOS match without enable, then with enable, then EOI
    lsn_act = 1; acc_data = 1; eos_hit = 1; eos_rx_en = 0; tick();
    chk("R3 eos without enable", stat1_o, 8'h00);
    eos_rx_en = 1; tick();
    chk("R3 eos with enable", stat1_o, 8'h08);
    eos_hit = 0; eos_rx_en = 0; rd1();
    eoi_line = 1; tick();
    chk("R3 eoi", stat1_o, 8'h08);
    eoi_line = 0; acc_data = 0; tick();
    lsn_act = 0; rd1();

    // R4 error, write while source idle
    src_idle = 1; host_dout_wr = 1; tick(); host_dout_wr = 0;
    chk("R4 write while idle", stat1_o, 8'h04);
    src_idle = 0; rd1();
    // R4 error, delay to idle
    src_delay = 1; hs_nrfd = 1; tick();
    chk("R4 delay state alone", stat1_o, 8'h00);
    src_delay = 0; src_idle = 1; tick();
    chk("R4 delay to idle", stat1_o, 8'h04);
    src_idle = 0; hs_nrfd = 0; rd1();
    // R4 error, talker in delay with no listener
    talker_act = 1; src_delay = 1; tick();
    chk("R4 no listener", stat1_o, 8'h04);
    talker_act = 0; src_delay = 0; tick(); rd1();

    // R5 data-out set and its two clears
    ev_dout_rdy = 1; tick(); ev_dout_rdy = 0;
    chk("R5 data-out set", stat1_o, 8'h02);
    host_dout_wr = 1; tick(); host_dout_wr = 0;
    chk("R5 host write clears", stat1_o, 8'h00);
    talker_act = 1; tick();
    ev_dout_rdy = 1; tick(); ev_dout_rdy = 0;
    chk("R5 data-out set again", stat1_o, 8'h02);
    talker_act = 0; tick();
    chk("R5 talker drop clears", stat1_o, 8'h00);

    // R6, R7, R2 change bits and command out
    remote_st = 0; tick();
    chk("R6 remote edge", stat2_o, 8'h02);
    lockout_st = 1; tick();
    chk("R6 lockout edge", stat2_o, 8'h06);
    addr_st[3] = 1; tick();
    chk("R7 address edge", stat2_o, 8'h0E);
    ev_cmd_out = 1; ev_din = 1; tick(); ev_cmd_out = 0; ev_din = 0;
    chk("R2 command out", stat2_o, 8'h0F);
    rd2();
    chk("R8 read2 clears", stat2_o, 8'h00);
    chk("R8 read2 leaves stat1", stat1_o, 8'h01);

    // R9 set and read in the same cycle
    rd_stat1 = 1; ev_din = 1; tick(); rd_stat1 = 0; ev_din = 0;
    chk("R9 set wins stat1", stat1_o, 8'h01);
    rd_stat2 = 1; remote_st = 1; tick(); rd_stat2 = 0;
    chk("R9 set wins stat2", stat2_o, 8'h02);
    rd2();

    // R10 interrupt masking, latency and polarity (stat1 = 01 now)
    mask_wdata = 8'h01; mask1_wr = 1; tick(); mask1_wr = 0;
    chk("R10 irq one cycle late", {7'd0, irq_o}, 8'h00);
    tick();
    chk("R10 irq raised", {7'd0, irq_o}, 8'h01);
    irq_invert = 1; tick();
    chk("R10 irq inverted", {7'd0, irq_o}, 8'h00);
    irq_invert = 0; rd1();
    chk("R10 irq from pre-read status", {7'd0, irq_o}, 8'h01);
    tick();
    chk("R10 irq drops", {7'd0, irq_o}, 8'h00);
    mask_wdata = 8'h02; mask2_wr = 1; tick(); mask2_wr = 0;
    remote_st = 0; tick(); tick();
    chk("R10 irq from stat2", {7'd0, irq_o}, 8'h01);
    rd2(); tick();

    // R11 everything at once; upper bits stay zero
    ev_din = 1; ev_dout_rdy = 1; ev_cmd_out = 1; lsn_act = 1; acc_data = 1;
    eoi_line = 1; lockout_st = 0; addr_st = 4'b1010; tick();
    {ev_din, ev_dout_rdy, ev_cmd_out, lsn_act, acc_data, eoi_line} = '0;
    chk("R11 stat1 upper bits", stat1_o & 8'hF0, 8'h00);
    chk("R11 stat2 upper bits", stat2_o & 8'hF0, 8'h00);
    chk("R2 all events stat1", stat1_o, 8'h0B);
    chk("R7 all events stat2", stat2_o, 8'h0D);
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule